// File: doc/BRIEF.md
# Firmware Hub Bus Target Engine

This block is the target side of a 4-bit multiplexed firmware-hub style bus. It samples a frame strobe and a nibble bus on every clock and recognises a memory write or memory read from the start nibble. It then compares a device-select nibble with its own identity, shifts in a nibble-serial address most significant nibble first, and checks that the size nibble asks for one byte. For a write it gathers the data byte low nibble first. For a read it fetches a byte from the memory side. It then takes part in the turnaround and sync handshake, driving its nibbles back onto the bus under an output-enable.

On the memory side the engine gives a one-clock write strobe with the address and data, or a one-clock read strobe with the address. The memory returns the read byte by the following clock. A frame whose start code, device select or size field is not supported is left alone: the engine never drives the bus for it and waits for the next frame strobe. A frame strobe seen in any state aborts the cycle in progress and starts decoding afresh.

Top module: `fwh_target`

## Requirements
- R1: A synchronous active-high reset returns the engine to idle. While reset is applied and in the clock after it, `nib_oe`, `mem_we` and `mem_re` are 0.
- R2: A clock with `frame_i` high and `nib_i` = 4'b1110 starts a write cycle. A clock with `frame_i` high and `nib_i` = 4'b1101 starts a read cycle.
- R3: The clock after the start carries the device-select nibble. If it differs from parameter `DEV_ID` (default 0), the engine raises no strobe and never asserts `nib_oe` until the next frame strobe.
- R4: Any other start nibble sampled with `frame_i` high is ignored in the same way as a mismatched device select.
- R5: The next 7 clocks carry the address, most significant nibble first. `mem_addr` holds the low `ADDR_W` bits (default 19) of the 28-bit value.
- R6: One size nibble follows the address. 4'b0000 selects a single-byte transfer. Any other value makes the engine ignore the rest of the cycle.
- R7: In a write, the two clocks after the size nibble carry the data, bits 3:0 first. In the clock after the second nibble, `mem_we` is 1 for exactly one clock and `mem_wdata` holds the byte.
- R8: After the host's last nibble the engine leaves `nib_oe` at 0 for two turnaround clocks. In the next clock it drives the sync nibble 4'b0000.
- R9: In a read, `mem_re` is 1 for one clock in the first turnaround clock, with the address on `mem_addr`. The byte on `mem_rdata` in the following clock is driven after the sync nibble, bits 3:0 in one clock and bits 7:4 in the next.
- R10: After its last sync or data nibble the engine drives 4'b1111 for one clock. It then sets `nib_oe` to 0 and returns to idle.
- R11: `frame_i` high in any state aborts the current cycle. The nibble sampled with it is decoded as a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | Frame strobe, active high, marks a start nibble |
| nib_i | input | 4 | Nibble bus as sampled from the host |
| nib_o | output | 4 | Nibble driven by the target |
| nib_oe | output | 1 | Output enable for `nib_o` |
| mem_we | output | 1 | One-clock memory write strobe |
| mem_re | output | 1 | One-clock memory read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid the clock after `mem_re` |

## Verification
The embedded properties check several rules on every cycle. The write strobe never lasts more than one clock. The bus is never driven in the clock right after a read strobe. A drive burst always opens with the ready sync nibble, and one that ends without an abort closes with 4'b1111. The output enable is low after reset. Only the directed scenarios can show that the nibbles land in the right address and data positions and that the read byte appears in low-then-high order. They also cover start codes, device selects and size fields that are refused without any drive, and a mid-address abort that still completes the cycle started after it.

// File: rtl/fwh_pkg.sv
`timescale 1ns/1ps
package fwh_pkg;

    localparam logic [3:0] START_WR   = 4'b1110;
    localparam logic [3:0] START_RD   = 4'b1101;
    localparam logic [3:0] SYNC_READY = 4'b0000;
    localparam logic [3:0] TAR_HIGH   = 4'b1111;
    localparam logic [3:0] SIZE_BYTE  = 4'b0000;
    localparam int         ADDR_NIBBLES = 7;
    localparam int         CNT_W = $clog2(ADDR_NIBBLES);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IGNORE,
        ST_IDSEL,
        ST_ADDR,
        ST_SIZE,
        ST_WLO,
        ST_WHI,
        ST_HTA0,
        ST_HTA1,
        ST_SYNC,
        ST_RLO,
        ST_RHI,
        ST_TTA
    } fwh_state_e;

    typedef struct packed {
        fwh_state_e       st;
        logic             wr;
        logic [CNT_W-1:0] cnt;
    } fwh_ctx_t;

    typedef struct packed {
        logic addr_shift;
        logic wlo_cap;
        logic whi_cap;
        logic rd_latch;
    } fwh_cap_t;

    function automatic logic is_start(input logic [3:0] n);
        return (n == START_WR) || (n == START_RD);
    endfunction

    function automatic logic target_drives(input fwh_state_e s);
        return (s == ST_SYNC) || (s == ST_RLO) || (s == ST_RHI) || (s == ST_TTA);
    endfunction

endpackage

// File: rtl/fwh_seq.sv
`timescale 1ns/1ps
module fwh_seq
    import fwh_pkg::*;
#(
    parameter logic [3:0] DEV_ID = 4'b0000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_i,
    input  logic [3:0] nib_i,
    output fwh_ctx_t   ctx,
    output fwh_cap_t   cap,
    output logic       we_pulse,
    output logic       re_pulse
);

    fwh_ctx_t nxt;

    always_comb begin
        nxt = ctx;
        if (frame_i) begin
            nxt.st  = is_start(nib_i) ? ST_IDSEL : ST_IGNORE;
            nxt.wr  = (nib_i == START_WR);
            nxt.cnt = '0;
        end else begin
            unique case (ctx.st)
                ST_IDLE:   nxt.st = ST_IDLE;
                ST_IGNORE: nxt.st = ST_IGNORE;
                ST_IDSEL: begin
                    nxt.st  = (nib_i == DEV_ID) ? ST_ADDR : ST_IGNORE;
                    nxt.cnt = '0;
                end
                ST_ADDR: begin
                    if (ctx.cnt == CNT_W'(ADDR_NIBBLES - 1)) begin
                        nxt.st = ST_SIZE;
                    end else begin
                        nxt.cnt = ctx.cnt + 1'b1;
                    end
                end
                ST_SIZE: begin
                    if (nib_i != SIZE_BYTE) nxt.st = ST_IGNORE;
                    else                    nxt.st = ctx.wr ? ST_WLO : ST_HTA0;
                end
                ST_WLO:  nxt.st = ST_WHI;
                ST_WHI:  nxt.st = ST_HTA0;
                ST_HTA0: nxt.st = ST_HTA1;
                ST_HTA1: nxt.st = ST_SYNC;
                ST_SYNC: nxt.st = ctx.wr ? ST_TTA : ST_RLO;
                ST_RLO:  nxt.st = ST_RHI;
                ST_RHI:  nxt.st = ST_TTA;
                ST_TTA:  nxt.st = ST_IDLE;
                default: nxt.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '{st: ST_IDLE, wr: 1'b0, cnt: '0};
        end else begin
            ctx <= nxt;
        end
    end

    always_comb begin
        cap.addr_shift = (ctx.st == ST_ADDR) && !frame_i;
        cap.wlo_cap    = (ctx.st == ST_WLO) && !frame_i;
        cap.whi_cap    = (ctx.st == ST_WHI) && !frame_i;
        cap.rd_latch   = (ctx.st == ST_HTA1);
    end

    assign we_pulse = (ctx.st == ST_HTA0) && ctx.wr;
    assign re_pulse = (ctx.st == ST_HTA0) && !ctx.wr;

    // R7: the write strobe never stays high two clocks running
    assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
        we_pulse |=> !we_pulse);

endmodule

// File: rtl/fwh_capture.sv
`timescale 1ns/1ps
module fwh_capture
    import fwh_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        nib_i,
    input  fwh_cap_t          cap,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wbyte,
    output logic [7:0]        rbyte
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            wbyte <= '0;
            rbyte <= '0;
        end else begin
            if (cap.addr_shift) addr <= {addr[ADDR_W-5:0], nib_i};
            if (cap.wlo_cap)    wbyte[3:0] <= nib_i;
            if (cap.whi_cap)    wbyte[7:4] <= nib_i;
            if (cap.rd_latch)   rbyte <= mem_rdata;
        end
    end

endmodule

// File: rtl/fwh_drive.sv
`timescale 1ns/1ps
module fwh_drive
    import fwh_pkg::*;
(
    input  fwh_state_e st,
    input  logic [7:0] rbyte,
    output logic [3:0] nib_o,
    output logic       nib_oe
);

    always_comb begin
        nib_o = TAR_HIGH;
        unique case (st)
            ST_SYNC: nib_o = SYNC_READY;
            ST_RLO:  nib_o = rbyte[3:0];
            ST_RHI:  nib_o = rbyte[7:4];
            default: nib_o = TAR_HIGH;
        endcase
    end

    assign nib_oe = target_drives(st);

endmodule

// File: rtl/fwh_target.sv
`timescale 1ns/1ps
module fwh_target
    import fwh_pkg::*;
#(
    parameter int         ADDR_W = 19,
    parameter logic [3:0] DEV_ID = 4'b0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_i,
    input  logic [3:0]        nib_i,
    output logic [3:0]        nib_o,
    output logic              nib_oe,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    fwh_ctx_t ctx;
    fwh_cap_t cap;
    logic [7:0] rbyte;

    fwh_seq #(.DEV_ID(DEV_ID)) u_seq (
        .clk(clk), .rst(rst), .frame_i(frame_i), .nib_i(nib_i),
        .ctx(ctx), .cap(cap), .we_pulse(mem_we), .re_pulse(mem_re)
    );

    fwh_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst(rst), .nib_i(nib_i), .cap(cap), .mem_rdata(mem_rdata),
        .addr(mem_addr), .wbyte(mem_wdata), .rbyte(rbyte)
    );

    fwh_drive u_drv (
        .st(ctx.st), .rbyte(rbyte), .nib_o(nib_o), .nib_oe(nib_oe)
    );

    // R1: bus released in the clock following reset
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !nib_oe);

    // R9: host turnaround follows the read strobe, so no drive next clock
    assert_no_drive_after_re_R9: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> !nib_oe);

    // R8: every drive burst opens with the ready sync nibble
    assert_sync_first_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(nib_oe) |-> (nib_o == SYNC_READY));

    // R10: a burst not cut short closes on the high turnaround nibble
    assert_close_high_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(nib_oe) && !$past(frame_i) && !$past(rst)) |-> ($past(nib_o) == TAR_HIGH));

endmodule

// File: tb/tb_fwh_target.sv
`timescale 1ns/1ps
module tb_fwh_target;

    localparam int ADDR_W = 19;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_i = 1'b0;
    logic [3:0]        nib_i = 4'hF;
    logic [3:0]        nib_o;
    logic              nib_oe;
    logic              mem_we;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fwh_target #(.ADDR_W(ADDR_W), .DEV_ID(4'h0)) dut (
        .clk(clk), .rst(rst), .frame_i(frame_i), .nib_i(nib_i),
        .nib_o(nib_o), .nib_oe(nib_oe), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] model_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    always_ff @(posedge clk) begin
        if (mem_re) mem_rdata <= model_byte(mem_addr);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic f, input logic [3:0] n);
        frame_i = f;
        nib_i   = n;
        @(posedge clk);
        #2;
    endtask

    task automatic header(input logic [3:0] code, input logic [3:0] id, input logic [27:0] a);
        tick(1'b1, code);
        tick(1'b0, id);
        for (int i = 6; i >= 0; i--) tick(1'b0, a[i*4 +: 4]);
    endtask

    task automatic do_write(input logic [27:0] a, input logic [7:0] d);
        header(4'b1110, 4'h0, a);
        tick(1'b0, 4'h0);
        tick(1'b0, d[3:0]);
        check(!mem_we && !nib_oe, "R7 no strobe before high nibble", mem_we, 0);
        tick(1'b0, d[7:4]);
        check(mem_we == 1'b1, "R7 write strobe", mem_we, 1);
        check(mem_wdata == d, "R7 write data", mem_wdata, d);
        check(mem_addr == a[ADDR_W-1:0], "R5 write address", mem_addr, a[ADDR_W-1:0]);
        tick(1'b0, 4'hF);
        check(!mem_we && !nib_oe, "R8 turnaround 2 idle, strobe ended R7", {mem_we, nib_oe}, 0);
        tick(1'b0, 4'hF);
        check(nib_oe && nib_o == 4'h0, "R8 write sync", {nib_oe, nib_o}, 5'h10);
        tick(1'b0, 4'hF);
        check(nib_oe && nib_o == 4'hF, "R10 write close high", {nib_oe, nib_o}, 5'h1F);
        tick(1'b0, 4'hF);
        check(!nib_oe, "R10 write release", nib_oe, 0);
    endtask

    task automatic do_read(input logic [27:0] a, input string tag);
        logic [7:0] e;
        e = model_byte(a[ADDR_W-1:0]);
        header(4'b1101, 4'h0, a);
        tick(1'b0, 4'h0);
        check(mem_re == 1'b1 && !nib_oe, {tag, " R9 read strobe"}, mem_re, 1);
        check(mem_addr == a[ADDR_W-1:0], {tag, " R5 read address"}, mem_addr, a[ADDR_W-1:0]);
        tick(1'b0, 4'hF);
        check(!mem_re && !nib_oe, {tag, " R8 read turnaround idle"}, {mem_re, nib_oe}, 0);
        tick(1'b0, 4'hF);
        check(nib_oe && nib_o == 4'h0, {tag, " R8 read sync"}, {nib_oe, nib_o}, 5'h10);
        tick(1'b0, 4'hF);
        check(nib_oe && nib_o == e[3:0], {tag, " R9 low nibble"}, nib_o, e[3:0]);
        tick(1'b0, 4'hF);
        check(nib_oe && nib_o == e[7:4], {tag, " R9 high nibble"}, nib_o, e[7:4]);
        tick(1'b0, 4'hF);
        check(nib_oe && nib_o == 4'hF, {tag, " R10 read close high"}, nib_o, 4'hF);
        tick(1'b0, 4'hF);
        check(!nib_oe, {tag, " R10 read release"}, nib_oe, 0);
    endtask

    // watch a refused frame for full cycle length; nothing may be driven
    task automatic refused(input logic [3:0] code, input logic [3:0] id, input logic [3:0] sz, input string req);
        bit bad;
        bad = 1'b0;
        tick(1'b1, code);
        bad |= nib_oe | mem_we | mem_re;
        tick(1'b0, id);
        bad |= nib_oe | mem_we | mem_re;
        for (int i = 0; i < 7; i++) begin
            tick(1'b0, 4'h5);
            bad |= nib_oe | mem_we | mem_re;
        end
        tick(1'b0, sz);
        for (int i = 0; i < 9; i++) begin
            tick(1'b0, 4'h0);
            bad |= nib_oe | mem_we | mem_re;
        end
        check(!bad, req, bad, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tick(1'b0, 4'hF);
        tick(1'b0, 4'hF);
        check(!nib_oe && !mem_we && !mem_re, "R1 reset state", {nib_oe, mem_we, mem_re}, 0);
        rst = 1'b0;
        tick(1'b0, 4'hF);
        check(!nib_oe, "R1 idle after reset", nib_oe, 0);
    endtask

    task automatic t_abort;
        tick(1'b1, 4'b1110);
        tick(1'b0, 4'h0);
        tick(1'b0, 4'h1);
        tick(1'b0, 4'h2);
        do_read(28'h0054321, "R11 abort then");
    endtask

    task automatic t_reset_mid;
        header(4'b1101, 4'h0, 28'h0011111);
        tick(1'b0, 4'h0);
        tick(1'b0, 4'hF);
        tick(1'b0, 4'hF);
        check(nib_oe == 1'b1, "R8 sync before reset", nib_oe, 1);
        rst = 1'b1;
        tick(1'b0, 4'hF);
        check(!nib_oe, "R1 reset mid cycle", nib_oe, 0);
        rst = 1'b0;
        tick(1'b0, 4'hF);
        tick(1'b0, 4'hF);
        check(!nib_oe && !mem_re, "R1 stays idle", nib_oe, 0);
    endtask

    initial begin
        tick(1'b0, 4'hF);
        t_reset();
        do_write(28'h0012345, 8'hA7);
        do_write(28'hFFFFFFF, 8'h5C);
        do_read(28'h00ABCDE, "R2 read");
        do_read(28'h0000000, "R2 zero");
        refused(4'b1110, 4'h3, 4'h0, "R3 id mismatch write");
        refused(4'b1101, 4'h8, 4'h0, "R3 id mismatch read");
        refused(4'b1010, 4'h0, 4'h0, "R4 bad start code");
        refused(4'b0000, 4'h0, 4'h0, "R4 zero start code");
        refused(4'b1101, 4'h0, 4'h1, "R6 size not byte");
        do_read(28'h0077F00, "R2 after refusals");
        t_abort();
        t_reset_mid();
        do_write(28'h0040001, 8'h01);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule